// File: doc/BRIEF.md
# CAN Transmit Mailbox State Controller

This block keeps the control and status state of a bank of CAN transmit mailboxes. The host programs a mailbox by writing its four-bit state code and its frame length. Identifier and payload words are held elsewhere as opaque storage and are not modelled here. A mailbox whose code is the "send once" value is armed. The block reports armed mailboxes to the arbitration scan, which is outside this block.

The protocol engine reports each finished transmission as a one-cycle pulse that carries a mailbox index. If that mailbox is still armed, the block does three things in the same clock edge: it captures the free-running timer into the mailbox stamp, it moves the code to the idle-transmit value, and it sets the mailbox event flag. The interrupt line is raised for every flag whose mask bit is set. If the host disarmed the mailbox while its frame was already on the bus, the completion pulse changes nothing.

An optional abort mode protects unacknowledged results. While that mode is on, a mailbox with a pending flag refuses host writes until the host clears the flag. Flags are cleared by writing ones.

Top module: `can_tx_mailbox_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every mailbox code is 4'b0000, and every length, stamp and flag is zero. The armed vector, the interrupt line and the timer are also zero.
- R2: The timer is 16 bits wide. It increases by one on every clock after reset and wraps from 16'hFFFF to 16'h0000.
- R3: A host write to mailbox k that is not locked updates the code and length of k on the next clock. Bit k of mb_armed is 1 exactly when the code of k is 4'b1100.
- R4: Writing code 4'b1000 to an armed mailbox disarms it: its armed bit is 0 after the next clock.
- R5: A completion pulse for a mailbox whose code is 4'b1100 has three effects on the next clock, all together. The stamp holds the timer value from the pulse cycle, the code becomes 4'b1000, and the flag bit is 1.
- R6: A completion pulse for a mailbox whose code is not 4'b1100 leaves its code, stamp and flag unchanged.
- R7: irq is 1 exactly when some mailbox has both its flag bit and its imask bit set.
- R8: A 1 in bit k of flag_clr clears flag k on the next clock. A 0 leaves it alone. A completion for k that sets the flag in the same cycle wins over the clear.
- R9: When abort_en is 1 and flag k is set, host writes to mailbox k change neither code nor length. After the flag is cleared, writes take effect again. When abort_en is 0, a set flag does not block writes.
- R10: When a host write and a completion for the same armed mailbox fall in the same cycle, the stamp and flag follow R5 and the code takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_en | input | 1 | Abort mode: flagged mailboxes lock against host writes |
| wr_en | input | 1 | Host control/status write strobe |
| wr_idx | input | 3 | Target mailbox of the host write |
| wr_code | input | 4 | Code value written |
| wr_len | input | 4 | Frame length written |
| flag_clr | input | 8 | Write-one-to-clear flag bits |
| imask | input | 8 | Interrupt mask, one bit per mailbox |
| done_valid | input | 1 | Transmission completed pulse from the protocol engine |
| done_idx | input | 3 | Mailbox whose frame completed |
| mb_code | output | 32 | Codes, mailbox k in bits [4k+3:4k] |
| mb_len | output | 32 | Lengths, mailbox k in bits [4k+3:4k] |
| mb_stamp | output | 128 | Stamps, mailbox k in bits [16k+15:16k] |
| mb_flag | output | 8 | Event flags |
| mb_armed | output | 8 | Mailboxes eligible for arbitration |
| irq | output | 1 | Interrupt request |
| timer_now | output | 16 | Free-running timer value |

## Verification
The assertions assume that the completion pulse lasts one cycle and that its index always names a real mailbox. They do not assume that the index names an armed mailbox, because completions on disarmed mailboxes must be tolerated. They also do not assume any spacing between host writes, clears and completions. The stimulus keeps both indices within the mailbox count. It lets writes, clears, mask changes, abort-mode toggles and completions collide freely on the same mailbox, including completions aimed at idle or disarmed mailboxes.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_RESET   = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_TX_IDLE = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_TX_ONCE = 4'b1100;

  // A mailbox takes part in arbitration only with this code.
  function automatic logic code_is_armed(input logic [CODE_W-1:0] c);
    return c == CODE_TX_ONCE;
  endfunction

  // Code a mailbox holds after its frame went out successfully.
  function automatic logic [CODE_W-1:0] code_after_tx(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] n;
    case (c)
      CODE_TX_ONCE: n = CODE_TX_IDLE;
      default:      n = c;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/can_mb_timer.sv
module can_mb_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/can_mb_slot.sv
module can_mb_slot
  import can_mb_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_en,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              done_hit,
  input  logic              clr_hit,
  input  logic [TS_W-1:0]   stamp_in,
  output logic [CODE_W-1:0] code_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [TS_W-1:0]   stamp_q,
  output logic              flag_q,
  output logic              armed,
  output logic              evt_done,
  output logic              evt_silent,
  output logic              evt_blocked
);
  logic locked;
  logic wr_take;

  assign locked      = abort_en & flag_q;
  assign wr_take     = wr_hit & ~locked;
  assign armed       = code_is_armed(code_q);
  assign evt_done    = done_hit & armed;
  assign evt_silent  = done_hit & ~armed;
  assign evt_blocked = wr_hit & locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= CODE_RESET;
      len_q   <= '0;
      stamp_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_take)       code_q <= wr_code;
      else if (evt_done) code_q <= code_after_tx(code_q);

      if (wr_take) len_q <= wr_len;

      if (evt_done) stamp_q <= stamp_in;

      if (evt_done)     flag_q <= 1'b1;
      else if (clr_hit) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/can_mb_irq.sv
module can_mb_irq #(
  parameter int N = 8
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] mask,
  output logic         irq
);
  assign irq = |(flags & mask);
endmodule

// File: rtl/can_tx_mailbox_ctrl.sv
module can_tx_mailbox_ctrl
  import can_mb_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int TS_W   = 16,
  parameter int LEN_W  = 4,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     abort_en,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [3:0]               wr_code,
  input  logic [LEN_W-1:0]         wr_len,
  input  logic [NUM_MB-1:0]        flag_clr,
  input  logic [NUM_MB-1:0]        imask,
  input  logic                     done_valid,
  input  logic [IDX_W-1:0]         done_idx,
  output logic [NUM_MB*4-1:0]      mb_code,
  output logic [NUM_MB*LEN_W-1:0]  mb_len,
  output logic [NUM_MB*TS_W-1:0]   mb_stamp,
  output logic [NUM_MB-1:0]        mb_flag,
  output logic [NUM_MB-1:0]        mb_armed,
  output logic                     irq,
  output logic [TS_W-1:0]          timer_now
);
  logic [NUM_MB-1:0] evt_done;
  logic [NUM_MB-1:0] evt_silent;
  logic [NUM_MB-1:0] evt_blocked;

  can_mb_timer #(.W(TS_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .count (timer_now)
  );

  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    logic wr_hit_g;
    logic done_hit_g;
    assign wr_hit_g   = wr_en      && (wr_idx   == IDX_W'(g));
    assign done_hit_g = done_valid && (done_idx == IDX_W'(g));

    can_mb_slot #(.TS_W(TS_W), .LEN_W(LEN_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .abort_en    (abort_en),
      .wr_hit      (wr_hit_g),
      .wr_code     (wr_code),
      .wr_len      (wr_len),
      .done_hit    (done_hit_g),
      .clr_hit     (flag_clr[g]),
      .stamp_in    (timer_now),
      .code_q      (mb_code[g*4 +: 4]),
      .len_q       (mb_len[g*LEN_W +: LEN_W]),
      .stamp_q     (mb_stamp[g*TS_W +: TS_W]),
      .flag_q      (mb_flag[g]),
      .armed       (mb_armed[g]),
      .evt_done    (evt_done[g]),
      .evt_silent  (evt_silent[g]),
      .evt_blocked (evt_blocked[g])
    );
  end

  can_mb_irq #(.N(NUM_MB)) u_irq (
    .flags (mb_flag),
    .mask  (imask),
    .irq   (irq)
  );
endmodule

// File: rtl/can_mb_chk.sv
module can_mb_chk #(
  parameter int NUM_MB = 8,
  parameter int TS_W   = 16,
  parameter int IDX_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   abort_en,
  input logic                   wr_en,
  input logic [IDX_W-1:0]       wr_idx,
  input logic [3:0]             wr_code,
  input logic [NUM_MB-1:0]      flag_clr,
  input logic [NUM_MB-1:0]      imask,
  input logic                   done_valid,
  input logic [IDX_W-1:0]       done_idx,
  input logic [NUM_MB*4-1:0]    mb_code,
  input logic [NUM_MB*TS_W-1:0] mb_stamp,
  input logic [NUM_MB-1:0]      mb_flag,
  input logic [NUM_MB-1:0]      mb_armed,
  input logic                   irq,
  input logic [TS_W-1:0]        timer_now,
  input logic [NUM_MB-1:0]      evt_done,
  input logic [NUM_MB-1:0]      evt_silent,
  input logic [NUM_MB-1:0]      evt_blocked
);
  p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> timer_now == TS_W'($past(timer_now) + 1'b1));

  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(mb_flag & imask)));

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic wr_i;
    logic done_i;
    assign wr_i   = wr_en      && (wr_idx   == IDX_W'(i));
    assign done_i = done_valid && (done_idx == IDX_W'(i));

    p_done_flag_stamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done[i] |=> mb_flag[i] && (mb_stamp[i*TS_W +: TS_W] == $past(timer_now)));

    p_done_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done[i] && !wr_i |=> mb_code[i*4 +: 4] == 4'b1000);

    p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_silent[i] && !wr_i && !flag_clr[i]
        |=> $stable(mb_code[i*4 +: 4]) && $stable(mb_stamp[i*TS_W +: TS_W]) && $stable(mb_flag[i]));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr[i] && !done_i |=> !mb_flag[i]);

    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_blocked[i] && !done_i |=> $stable(mb_code[i*4 +: 4]));

    p_lock_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_blocked[i] |-> abort_en && mb_flag[i]);

    p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && wr_code == 4'b1000 && !(abort_en && mb_flag[i]) |=> !mb_armed[i]);
  end
endmodule

bind can_tx_mailbox_ctrl can_mb_chk #(
  .NUM_MB (NUM_MB),
  .TS_W   (TS_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_en    (abort_en),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_code     (wr_code),
  .flag_clr    (flag_clr),
  .imask       (imask),
  .done_valid  (done_valid),
  .done_idx    (done_idx),
  .mb_code     (mb_code),
  .mb_stamp    (mb_stamp),
  .mb_flag     (mb_flag),
  .mb_armed    (mb_armed),
  .irq         (irq),
  .timer_now   (timer_now),
  .evt_done    (evt_done),
  .evt_silent  (evt_silent),
  .evt_blocked (evt_blocked)
);

// File: tb/tb_can_tx_mailbox_ctrl.sv
`timescale 1ns/1ps
module tb_can_tx_mailbox_ctrl;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int TW = 16;
  localparam int LW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            abort_en;
  logic            wr_en;
  logic [IW-1:0]   wr_idx;
  logic [3:0]      wr_code;
  logic [LW-1:0]   wr_len;
  logic [N-1:0]    flag_clr;
  logic [N-1:0]    imask;
  logic            done_valid;
  logic [IW-1:0]   done_idx;
  logic [N*4-1:0]  mb_code;
  logic [N*LW-1:0] mb_len;
  logic [N*TW-1:0] mb_stamp;
  logic [N-1:0]    mb_flag;
  logic [N-1:0]    mb_armed;
  logic            irq;
  logic [TW-1:0]   timer_now;

  can_tx_mailbox_ctrl dut (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_code(wr_code), .wr_len(wr_len), .flag_clr(flag_clr), .imask(imask),
    .done_valid(done_valid), .done_idx(done_idx), .mb_code(mb_code), .mb_len(mb_len),
    .mb_stamp(mb_stamp), .mb_flag(mb_flag), .mb_armed(mb_armed), .irq(irq),
    .timer_now(timer_now)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [3:0]    e_code [N];
  logic [LW-1:0] e_len  [N];
  logic [TW-1:0] e_ts   [N];
  logic          e_flag [N];
  logic [TW-1:0] e_timer;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Requirement model: a mailbox is armed only with code 4'b1100.
  function automatic logic armed_code(input logic [3:0] c);
    return c == 4'b1100;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int i = 0; i < N; i++) r = r | (e_flag[i] & imask[i]);
    return r;
  endfunction

  task automatic compare(input string tag);
    for (int i = 0; i < N; i++) begin
      chk(tag, $sformatf("code[%0d]", i),  32'(mb_code[i*4 +: 4]),    32'(e_code[i]));
      chk(tag, $sformatf("len[%0d]", i),   32'(mb_len[i*LW +: LW]),   32'(e_len[i]));
      chk(tag, $sformatf("stamp[%0d]", i), 32'(mb_stamp[i*TW +: TW]), 32'(e_ts[i]));
      chk(tag, $sformatf("flag[%0d]", i),  32'(mb_flag[i]),           32'(e_flag[i]));
      chk(tag, $sformatf("armed[%0d]", i), 32'(mb_armed[i]),          32'(armed_code(e_code[i])));
    end
    chk(tag, "irq",   32'(irq),       32'(exp_irq()));
    chk(tag, "timer", 32'(timer_now), 32'(e_timer));
  endtask

  // Inputs are already driven; advance one clock and check the model.
  task automatic step(input string tag);
    logic [3:0]    n_code [N];
    logic [LW-1:0] n_len  [N];
    logic [TW-1:0] n_ts   [N];
    logic          n_flag [N];
    for (int i = 0; i < N; i++) begin
      logic hit_done, wr_ok;
      hit_done = done_valid && (int'(done_idx) == i) && armed_code(e_code[i]);
      wr_ok    = wr_en && (int'(wr_idx) == i) && !(abort_en && e_flag[i]);
      n_flag[i] = hit_done ? 1'b1 : (flag_clr[i] ? 1'b0 : e_flag[i]);
      n_code[i] = wr_ok ? wr_code : (hit_done ? 4'b1000 : e_code[i]);
      n_len[i]  = wr_ok ? wr_len : e_len[i];
      n_ts[i]   = hit_done ? e_timer : e_ts[i];
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      e_code[i] = n_code[i]; e_len[i] = n_len[i]; e_ts[i] = n_ts[i]; e_flag[i] = n_flag[i];
    end
    e_timer = e_timer + 1'b1;
    compare(tag);
    wr_en = 1'b0; done_valid = 1'b0; flag_clr = '0;
  endtask

  task automatic host_wr(input int idx, input logic [3:0] c, input logic [LW-1:0] l, input string tag);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_code = c; wr_len = l;
    step(tag);
  endtask

  task automatic complete(input int idx, input string tag);
    done_valid = 1'b1; done_idx = IW'(idx);
    step(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    rst_n = 1'b0; abort_en = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_code = '0; wr_len = '0;
    flag_clr = '0; imask = '0; done_valid = 1'b0; done_idx = '0;
    for (int i = 0; i < N; i++) begin
      e_code[i] = 4'b0000; e_len[i] = '0; e_ts[i] = '0; e_flag[i] = 1'b0;
    end
    e_timer = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    compare("R1 after release");

    // R3: arm mailbox 2
    host_wr(2, 4'b1100, 4'd8, "R3 arm");
    chk("R3", "armed bit 2", 32'(mb_armed[2]), 32'd1);
    // R4: disarm
    host_wr(2, 4'b1000, 4'd8, "R4 disarm");
    chk("R4", "armed bit 2", 32'(mb_armed[2]), 32'd0);
    // R5 and R7: rearm, complete with mask set
    imask = 8'h04;
    host_wr(2, 4'b1100, 4'd3, "R3 rearm");
    repeat (5) step("R2 idle");
    complete(2, "R5 complete");
    chk("R5", "code 2", 32'(mb_code[8 +: 4]), 32'h8);
    chk("R7", "irq", 32'(irq), 32'd1);
    imask = 8'h00;
    step("R7 masked");
    chk("R7", "irq masked", 32'(irq), 32'd0);
    // R8: clear
    flag_clr = 8'h04;
    step("R8 clear");
    chk("R8", "flag 2", 32'(mb_flag[2]), 32'd0);
    // R6: completion of a disarmed mailbox
    host_wr(4, 4'b1100, 4'd1, "R3 arm 4");
    host_wr(4, 4'b1000, 4'd1, "R4 disarm 4");
    complete(4, "R6 silent");
    chk("R6", "flag 4", 32'(mb_flag[4]), 32'd0);
    // R9: abort lock
    abort_en = 1'b1;
    host_wr(5, 4'b1100, 4'd2, "R9 arm 5");
    complete(5, "R9 complete 5");
    host_wr(5, 4'b1100, 4'd7, "R9 locked write");
    chk("R9", "code 5 locked", 32'(mb_code[20 +: 4]), 32'h8);
    flag_clr = 8'h20;
    step("R9 clear 5");
    host_wr(5, 4'b1100, 4'd7, "R9 unlocked write");
    chk("R9", "code 5 unlocked", 32'(mb_code[20 +: 4]), 32'hC);
    abort_en = 1'b0;
    complete(5, "R9 complete again");
    host_wr(5, 4'b0000, 4'd6, "R9 no lock without abort");
    chk("R9", "code 5 written", 32'(mb_code[20 +: 4]), 32'h0);
    // R10: write and completion together
    host_wr(1, 4'b1100, 4'd4, "R10 arm 1");
    wr_en = 1'b1; wr_idx = 3'd1; wr_code = 4'b0100; wr_len = 4'd9;
    done_valid = 1'b1; done_idx = 3'd1;
    step("R10 collide");
    chk("R10", "code 1", 32'(mb_code[4 +: 4]), 32'h4);
    chk("R10", "flag 1", 32'(mb_flag[1]), 32'd1);
    // R8: clear loses against completion
    host_wr(1, 4'b1100, 4'd4, "R8 rearm 1");
    flag_clr = 8'h02; done_valid = 1'b1; done_idx = 3'd1;
    step("R8 set wins");
    chk("R8", "flag 1", 32'(mb_flag[1]), 32'd1);

    // Random phase (R3 R5 R6 R8 R9 R10)
    for (int k = 0; k < 4000; k++) begin
      int sel;
      wr_en = ($urandom % 3) == 0;
      wr_idx = IW'($urandom % N);
      sel = $urandom % 4;
      wr_code = (sel == 0) ? 4'b1000 : (sel == 1) ? 4'b1100 : (sel == 2) ? 4'b1100 : 4'($urandom);
      wr_len = LW'($urandom);
      done_valid = ($urandom % 3) == 0;
      done_idx = IW'($urandom % N);
      flag_clr = (($urandom % 4) == 0) ? N'($urandom) : '0;
      if (($urandom % 16) == 0) imask = N'($urandom);
      if (($urandom % 64) == 0) abort_en = ~abort_en;
      step("R5 R6 R9 random");
    end

    // R2: timer wrap
    wr_en = 1'b0; done_valid = 1'b0; flag_clr = '0;
    while (e_timer != 16'hFFFF) step("R2 count");
    chk("R2", "timer at max", 32'(timer_now), 32'hFFFF);
    step("R2 wrap");
    chk("R2", "timer wrapped", 32'(timer_now), 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule